// File: doc/BRIEF.md
# Exception Control Register File

This block holds the machine state that a simple 32-bit RISC core needs to take and return from exceptions. It keeps four registers: the return address of the faulting instruction, a cause register (exception code plus pending interrupt bits), the last faulting data or fetch address, and a status word. The status word carries an 8-bit interrupt mask and a three-level stack of (user mode, interrupt enable) pairs.

The core pulses a one-cycle exception strobe with a 4-bit code, its already incremented PC and the faulting address. It pulses a return strobe when the handler finishes. Six external interrupt lines are latched into sticky pending bits. From these, the block raises an interrupt request whenever an unmasked pending bit exists and interrupts are enabled. Software reads and writes the registers by register number. The handler entry address is a fixed output.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset, all four registers read 0 and `irq_req` is 0 (kernel mode, interrupts disabled).
- R2: On `exc_valid`, status bits 5:0 become {old bits 3:0, 2'b00}, so the current pair (bits 1:0) is kernel mode with interrupts disabled; the mask in bits 15:8 is kept.
- R3: On `eret_valid` (without `exc_valid`), status bits 3:0 take the old bits 5:2 and bits 5:4 are unchanged.
- R4: On `exc_valid`, the return-address register (number 14) becomes `exc_pc_next - 4`; software writes to register 14 load it otherwise.
- R5: On `exc_valid`, cause bits 5:2 take `exc_code` (0 external interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 system call, 9 breakpoint, 10 reserved instruction, 12 overflow); the code holds otherwise and software cannot write it.
- R6: The bad-address register (number 8) loads `exc_bad_addr` only on an exception with code 4 or 5; other codes leave it unchanged.
- R7: `irq_lines[i]` sets cause bit 10+i at the next edge whatever the enable state; the bit stays set until a software write to cause (number 13) carries 0 in that bit, and a line that is high in the same cycle wins.
- R8: `irq_req` is 1 exactly when some cause bit 15:8 ANDed with status bit at the same position is 1 and status bit 0 (current enable) is 1.
- R9: `handler_pc` is constant 0x8000_0080.
- R10: Register numbers are 8 bad address, 12 status, 13 cause, 14 return address; any other number reads 0 and ignores writes; register 8 ignores software writes.
- R11: Status bits 31:16 and 7:6 and cause bits 31:16, 7:6 and 1:0 read 0 and ignore writes.
- R12: Priority in one cycle is exception, then return, then software write: a software write to status or cause is dropped when `exc_valid` is high, and a status write is dropped when `eret_valid` is high.
- R13: Cause bits 9:8 are software interrupt requests loaded directly by a write to cause, and take part in R8 like the hardware bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_code | input | 4 | Exception code |
| exc_pc_next | input | 32 | Incremented PC of the faulting instruction |
| exc_bad_addr | input | 32 | Faulting memory address |
| eret_valid | input | 1 | One-cycle return-from-exception strobe |
| irq_lines | input | 6 | External interrupt request lines |
| reg_addr | input | 5 | Register number for read and write |
| reg_wr_en | input | 1 | Software write enable |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| handler_pc | output | 32 | Handler entry address |

## Verification
Every strobe, software write or interrupt line is sampled at one rising edge. Its effect is visible on `reg_rdata` and `irq_req` right after that edge, because the read path and the request are combinational from the registers. The bench drives each stimulus for exactly one edge and samples 1 ns after it. It reads registers by changing `reg_addr` with writes off before the next edge. A bench model updated at the same edge gives the expected values for a seeded random mix of strobes, writes and interrupt lines. Directed sequences cover stack push and pop, sticky pending bits with interrupts disabled, masking, address-error-only capture and same-cycle strobe priority.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    localparam int XLEN     = 32;
    localparam int IRQ_HW   = 6;
    localparam int IRQ_SW   = 2;
    localparam int IRQ_N    = IRQ_HW + IRQ_SW;
    localparam int STK_W    = 6;
    localparam int CODE_W   = 4;
    localparam int REGNUM_W = 5;

    // bit positions that software decodes
    localparam int MASK_LSB = 8;
    localparam int SWP_LSB  = 8;
    localparam int HWP_LSB  = SWP_LSB + IRQ_SW;
    localparam int CODE_LSB = 2;
    localparam int USED_W   = 16;

    localparam logic [REGNUM_W-1:0] REGNUM_BAD    = 5'd8;
    localparam logic [REGNUM_W-1:0] REGNUM_STATUS = 5'd12;
    localparam logic [REGNUM_W-1:0] REGNUM_CAUSE  = 5'd13;
    localparam logic [REGNUM_W-1:0] REGNUM_EPC    = 5'd14;

    localparam logic [CODE_W-1:0] CODE_ADDR_LD = 4'd4;
    localparam logic [CODE_W-1:0] CODE_ADDR_ST = 4'd5;

    typedef struct packed {
        logic [IRQ_N-1:0] mask;
        logic [STK_W-1:0] stk;
    } status_t;

    typedef struct packed {
        logic [IRQ_HW-1:0] hw;
        logic [IRQ_SW-1:0] sw;
        logic [CODE_W-1:0] code;
    } cause_t;

    function automatic logic [STK_W-1:0] stk_push(input logic [STK_W-1:0] s);
        return {s[STK_W-3:0], 2'b00};
    endfunction

    function automatic logic [STK_W-1:0] stk_pop(input logic [STK_W-1:0] s);
        return {s[STK_W-1:STK_W-2], s[STK_W-1:2]};
    endfunction

    function automatic logic is_addr_err(input logic [CODE_W-1:0] c);
        return (c == CODE_ADDR_LD) || (c == CODE_ADDR_ST);
    endfunction

    function automatic logic [XLEN-1:0] pack_status(input status_t s);
        return {{(XLEN-USED_W){1'b0}}, s.mask, 2'b00, s.stk};
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(input cause_t c);
        return {{(XLEN-USED_W){1'b0}}, c.hw, c.sw, 2'b00, c.code, 2'b00};
    endfunction

endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    exc_i,
    input  logic    eret_i,
    input  logic    wr_i,
    input  status_t wdata_i,
    output status_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (exc_i) begin
            q_o.stk <= stk_push(q_o.stk);
        end else if (eret_i) begin
            q_o.stk <= stk_pop(q_o.stk);
        end else if (wr_i) begin
            q_o <= wdata_i;
        end
    end

    AST_PUSH_KERNEL: assert property (@(posedge clk) disable iff (rst)
        exc_i |=> (q_o.stk[1:0] == 2'b00)); // R2
    AST_PUSH_SAVE: assert property (@(posedge clk) disable iff (rst)
        exc_i |=> (q_o.stk[3:2] == $past(q_o.stk[1:0]))); // R2
    AST_POP_OLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (eret_i && !exc_i) |=> $stable(q_o.stk[5:4])); // R3
    AST_STROBE_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (exc_i || eret_i) |=> $stable(q_o.mask)); // R12

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [IRQ_HW-1:0] irq_i,
    input  logic              wr_i,
    input  logic [IRQ_HW-1:0] keep_i,
    input  logic [IRQ_SW-1:0] sw_i,
    output cause_t            q_o
);

    logic              wr_take;
    logic [IRQ_HW-1:0] hw_d;

    assign wr_take = wr_i & ~exc_i;

    for (genvar i = 0; i < IRQ_HW; i++) begin : g_pend
        assign hw_d[i] = (wr_take ? (q_o.hw[i] & keep_i[i]) : q_o.hw[i]) | irq_i[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            q_o.hw <= hw_d;
            if (wr_take) q_o.sw   <= sw_i;
            if (exc_i)   q_o.code <= code_i;
        end
    end

    AST_PEND_LATCH: assert property (@(posedge clk) disable iff (rst)
        (|irq_i) |=> ((q_o.hw & $past(irq_i)) == $past(irq_i))); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_take |=> ((q_o.hw & $past(q_o.hw)) == $past(q_o.hw))); // R7
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exc_i |=> $stable(q_o.code)); // R5

endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
    import exc_ctrl_pkg::*;
#(
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   pc_next_i,
    input  logic [XLEN-1:0]   bad_i,
    input  logic              epc_wr_i,
    input  logic [XLEN-1:0]   epc_wdata_i,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   bad_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_o <= '0;
            bad_o <= '0;
        end else begin
            if (exc_i)         epc_o <= pc_next_i - STEP;
            else if (epc_wr_i) epc_o <= epc_wdata_i;
            if (exc_i && is_addr_err(code_i)) bad_o <= bad_i;
        end
    end

    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(exc_i && is_addr_err(code_i)) |=> $stable(bad_o)); // R6
    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exc_i && !epc_wr_i) |=> $stable(epc_o)); // R4

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
    import exc_ctrl_pkg::*;
#(
    parameter logic [31:0] HANDLER_PC = 32'h8000_0080
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_valid,
    input  logic [3:0]  exc_code,
    input  logic [31:0] exc_pc_next,
    input  logic [31:0] exc_bad_addr,
    input  logic        eret_valid,
    input  logic [5:0]  irq_lines,
    input  logic [4:0]  reg_addr,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_req,
    output logic [31:0] handler_pc
);

    status_t         status_q;
    status_t         status_w;
    cause_t          cause_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] bad_q;
    logic            wr_status;
    logic            wr_cause;
    logic            wr_epc;

    assign wr_status = reg_wr_en && (reg_addr == REGNUM_STATUS);
    assign wr_cause  = reg_wr_en && (reg_addr == REGNUM_CAUSE);
    assign wr_epc    = reg_wr_en && (reg_addr == REGNUM_EPC);

    assign status_w.mask = reg_wdata[MASK_LSB +: IRQ_N];
    assign status_w.stk  = reg_wdata[0 +: STK_W];

    exc_status_reg u_status (
        .clk     (clk),
        .rst     (rst),
        .exc_i   (exc_valid),
        .eret_i  (eret_valid),
        .wr_i    (wr_status),
        .wdata_i (status_w),
        .q_o     (status_q)
    );

    exc_cause_reg u_cause (
        .clk    (clk),
        .rst    (rst),
        .exc_i  (exc_valid),
        .code_i (exc_code),
        .irq_i  (irq_lines),
        .wr_i   (wr_cause),
        .keep_i (reg_wdata[HWP_LSB +: IRQ_HW]),
        .sw_i   (reg_wdata[SWP_LSB +: IRQ_SW]),
        .q_o    (cause_q)
    );

    exc_addr_regs u_addr (
        .clk         (clk),
        .rst         (rst),
        .exc_i       (exc_valid),
        .code_i      (exc_code),
        .pc_next_i   (exc_pc_next),
        .bad_i       (exc_bad_addr),
        .epc_wr_i    (wr_epc),
        .epc_wdata_i (reg_wdata),
        .epc_o       (epc_q),
        .bad_o       (bad_q)
    );

    always_comb begin
        case (reg_addr)
            REGNUM_BAD:    reg_rdata = bad_q;
            REGNUM_STATUS: reg_rdata = pack_status(status_q);
            REGNUM_CAUSE:  reg_rdata = pack_cause(cause_q);
            REGNUM_EPC:    reg_rdata = epc_q;
            default:       reg_rdata = '0;
        endcase
    end

    assign irq_req    = (|({cause_q.hw, cause_q.sw} & status_q.mask)) & status_q.stk[0];
    assign handler_pc = HANDLER_PC;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> status_q.stk[0]); // R8
    AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REGNUM_STATUS || reg_addr == REGNUM_CAUSE)
        |-> (reg_rdata[XLEN-1:USED_W] == '0 && reg_rdata[7:6] == 2'b00)); // R11
    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(reg_addr == REGNUM_BAD || reg_addr == REGNUM_STATUS ||
          reg_addr == REGNUM_CAUSE || reg_addr == REGNUM_EPC)
        |-> (reg_rdata == '0)); // R10

endmodule

// File: tb/exc_ctrl_regs_tb.sv
`timescale 1ns/1ps
module exc_ctrl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_valid;
    logic [3:0]  exc_code;
    logic [31:0] exc_pc_next;
    logic [31:0] exc_bad_addr;
    logic        eret_valid;
    logic [5:0]  irq_lines;
    logic [4:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [31:0] handler_pc;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [7:0]  m_mask;
    logic [5:0]  m_stk;
    logic [5:0]  m_hw;
    logic [1:0]  m_sw;
    logic [3:0]  m_code;
    logic [31:0] m_epc;
    logic [31:0] m_bad;

    always #5 clk = ~clk;

    exc_ctrl_regs dut_i (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc_next(exc_pc_next), .exc_bad_addr(exc_bad_addr),
        .eret_valid(eret_valid), .irq_lines(irq_lines), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .handler_pc(handler_pc)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'd8:    return m_bad;
            5'd12:   return {16'h0, m_mask, 2'b00, m_stk};
            5'd13:   return {16'h0, m_hw, m_sw, 2'b00, m_code, 2'b00};
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (|({m_hw, m_sw} & m_mask)) & m_stk[0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        reg_wr_en = 1'b0;
        reg_addr  = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic step(input logic e, input logic [3:0] c, input logic [31:0] pc,
                        input logic [31:0] ba, input logic r, input logic w,
                        input logic [4:0] a, input logic [31:0] d, input logic [5:0] irq);
        exc_valid = e; exc_code = c; exc_pc_next = pc; exc_bad_addr = ba;
        eret_valid = r; reg_wr_en = w; reg_addr = a; reg_wdata = d; irq_lines = irq;
        @(posedge clk);
        if (e)                 m_stk = {m_stk[3:0], 2'b00};
        else if (r)            m_stk = {m_stk[5:4], m_stk[5:2]};
        else if (w && a == 12) begin m_mask = d[15:8]; m_stk = d[5:0]; end
        if (w && a == 13 && !e) begin m_hw = m_hw & d[15:10]; m_sw = d[9:8]; end
        m_hw = m_hw | irq;
        if (e) m_code = c;
        if (e) m_epc = pc - 32'd4;
        else if (w && a == 14) m_epc = d;
        if (e && (c == 4'd4 || c == 4'd5)) m_bad = ba;
        #1;
        exc_valid = 1'b0; eret_valid = 1'b0; reg_wr_en = 1'b0; irq_lines = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1'b0, 4'd0, 32'h0, 32'h0, 1'b0, 1'b1, a, d, 6'h0);
    endtask

    function automatic logic [3:0] pick_code();
        case ($urandom % 10)
            0: return 4'd0;  1: return 4'd4;  2: return 4'd5;
            3: return 4'd6;  4: return 4'd7;  5: return 4'd8;
            6: return 4'd9;  7: return 4'd10; 8: return 4'd12;
            default: return 4'($urandom);
        endcase
    endfunction

    function automatic logic [4:0] pick_addr();
        case ($urandom % 5)
            0: return 5'd8;  1: return 5'd12; 2: return 5'd13;
            3: return 5'd14; default: return 5'($urandom);
        endcase
    endfunction

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20417));
        rst = 1'b1; exc_valid = 0; exc_code = 0; exc_pc_next = 0; exc_bad_addr = 0;
        eret_valid = 0; irq_lines = 0; reg_addr = 0; reg_wr_en = 0; reg_wdata = 0;
        m_mask = 0; m_stk = 0; m_hw = 0; m_sw = 0; m_code = 0; m_epc = 0; m_bad = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        peek(5'd8, v);  chk("R1 bad", v, 32'h0);
        peek(5'd12, v); chk("R1 status", v, 32'h0);
        peek(5'd13, v); chk("R1 cause", v, 32'h0);
        peek(5'd14, v); chk("R1 epc", v, 32'h0);
        chk("R1 irq_req", {31'h0, irq_req}, 32'h0);
        chk("R9 handler", handler_pc, 32'h8000_0080);

        // R11 unused status bits
        wr(5'd12, 32'hFFFF_FFFD);
        peek(5'd12, v); chk("R11 status", v, 32'h0000_FF3D);

        // R2 R4 R5 R6 overflow exception
        step(1'b1, 4'd12, 32'h1000_0008, 32'hAAAA_0000, 1'b0, 1'b0, 5'd0, 32'h0, 6'h0);
        peek(5'd12, v); chk("R2 push", v, 32'h0000_FF34);
        peek(5'd14, v); chk("R4 epc", v, 32'h1000_0004);
        peek(5'd13, v); chk("R5 code", v, 32'h0000_0030);
        peek(5'd8, v);  chk("R6 bad kept", v, 32'h0);

        // R3 return pops
        step(1'b0, 4'd0, 32'h0, 32'h0, 1'b1, 1'b0, 5'd0, 32'h0, 6'h0);
        peek(5'd12, v); chk("R3 pop", v, 32'h0000_FF3D);

        // R6 address error captures
        step(1'b1, 4'd4, 32'h2000_0000, 32'hDEAD_BEEC, 1'b0, 1'b0, 5'd0, 32'h0, 6'h0);
        peek(5'd8, v);  chk("R6 bad load", v, 32'hDEAD_BEEC);
        peek(5'd13, v); chk("R5 code4", v, 32'h0000_0010);
        peek(5'd14, v); chk("R4 epc2", v, 32'h1FFF_FFFC);

        // R10 read-only and unmapped numbers
        wr(5'd8, 32'h0000_1234);
        peek(5'd8, v);  chk("R10 bad ro", v, 32'hDEAD_BEEC);
        wr(5'd3, 32'hFFFF_FFFF);
        peek(5'd3, v);  chk("R10 unmapped", v, 32'h0);
        peek(5'd12, v); chk("R10 status kept", v, 32'h0000_FF34);

        // R7 R8 pending while disabled
        wr(5'd12, 32'h0000_FF00);
        step(1'b0, 4'd0, 32'h0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 6'b000100);
        peek(5'd13, v); chk("R7 latch", v, 32'h0000_1010);
        chk("R8 disabled", {31'h0, irq_req}, 32'h0);
        step(1'b0, 4'd0, 32'h0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 6'h0);
        peek(5'd13, v); chk("R7 sticky", v, 32'h0000_1010);
        wr(5'd12, 32'h0000_FF01);
        chk("R8 enabled", {31'h0, irq_req}, 32'h1);
        wr(5'd13, 32'h0000_0000);
        peek(5'd13, v); chk("R7 clear", v, 32'h0000_0010);
        chk("R7 clear irq", {31'h0, irq_req}, 32'h0);

        // R13 software request and masking
        wr(5'd13, 32'h0000_0100);
        peek(5'd13, v); chk("R13 sw", v, 32'h0000_0110);
        chk("R13 irq", {31'h0, irq_req}, 32'h1);
        wr(5'd12, 32'h0000_FE01);
        chk("R8 masked", {31'h0, irq_req}, 32'h0);

        // R12 same-cycle priority
        step(1'b1, 4'd8, 32'h3000_0010, 32'h0, 1'b1, 1'b1, 5'd12, 32'h0000_FFFF, 6'h0);
        peek(5'd12, v); chk("R12 exc wins", v, 32'h0000_FE04);
        peek(5'd13, v); chk("R12 cause", v, 32'h0000_0120);
        step(1'b0, 4'd0, 32'h0, 32'h0, 1'b1, 1'b1, 5'd12, 32'h0, 6'h0);
        peek(5'd12, v); chk("R12 eret wins", v, 32'h0000_FE01);
        step(1'b1, 4'd9, 32'h4000_0008, 32'h0, 1'b0, 1'b1, 5'd13, 32'h0, 6'h0);
        peek(5'd13, v); chk("R12 cause wr dropped", v, 32'h0000_0124);

        // random mix checked against the model
        for (int i = 0; i < 2500; i++) begin
            logic        e, r, w;
            logic [4:0]  a, pa;
            logic [5:0]  irq;
            e   = ($urandom % 8) == 0;
            r   = ($urandom % 8) == 0;
            w   = ($urandom % 2) == 0;
            a   = pick_addr();
            irq = 6'($urandom) & 6'($urandom) & 6'($urandom);
            step(e, pick_code(), $urandom, $urandom, r, w, a, $urandom, irq);
            pa = pick_addr();
            peek(pa, v);
            case (pa)
                5'd8:    chk("R6 rand", v, exp_read(pa));
                5'd12:   chk("R2 rand", v, exp_read(pa));
                5'd13:   chk("R7 rand", v, exp_read(pa));
                5'd14:   chk("R4 rand", v, exp_read(pa));
                default: chk("R10 rand", v, exp_read(pa));
            endcase
            chk("R8 rand", {31'h0, irq_req}, {31'h0, exp_irq()});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule